// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast clock by a programmable integer N and emits one pulse, a single input clock wide, every N input cycles. It is meant for the feedback path of a frequency synthesizer, where the divided pulse goes to a phase detector. Only a small prescaler runs at the full input rate, and it counts by either 4 or 5. Two slower counters set how the prescaler moduli are mixed. The A counter sets how many prescaler cycles use the divide-by-5 setting. The M counter sets how many prescaler cycles make up one sweep. One sweep therefore lasts 4·M + A input cycles.

A doubling control makes the output pulse appear only on every second sweep. This extends the reachable moduli to even values up to twice the base range. New settings of A, M and the doubling control are taken only at the edge that ends an output period. Software can therefore rewrite them at any time without producing a short or stretched period.

Top module: `fbdiv_top`

## Requirements
- R1: With doubling off, `pulse_out` is high for exactly one clock cycle and rises once every N = 4·M + A clock cycles, where M is the value on `m_in` (7 bits, unsigned) and A is the value on `a_in` (2 bits, unsigned).
- R2: Within each sweep, the prescaler counts 5 input cycles for each of the first A prescaler cycles and 4 input cycles for each of the remaining M − A prescaler cycles. As a result, raising A by one lengthens the period by exactly one cycle.
- R3: With `dbl_in` = 1 the pulse is issued on every second sweep only, so the period is 2·(4·M + A), still one cycle wide.
- R4: `a_in`, `m_in` and `dbl_in` are sampled only on the clock edge at which `pulse_out` rises (and on the first edge after reset). Changes between those edges do not alter the period in progress.
- R5: An `m_in` value below 9 is treated as 9, and a value above 98 is treated as 98.
- R6: While `rst_n` is low, `pulse_out` is 0. The first rising edge after release samples the settings, and `pulse_out` first rises on the (N+1)-th rising edge after release.
- R7: Every A value from 0 to 3 is legal with every M in range. A = 0 gives a sweep made only of divide-by-4 prescaler cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 2 | Number of divide-by-5 prescaler cycles per sweep |
| m_in | input | 7 | Number of prescaler cycles per sweep (clamped to 9..98) |
| dbl_in | input | 1 | 1 = issue a pulse on every second sweep |
| pulse_out | output | 1 | Registered divided pulse, one clock wide |

## Verification
The hardest case to reach from the ports is a change of settings that lands in the middle of a period. If the design is wrong here, the change leaks into the current sweep, but the only visible sign is one interval that is slightly off. The bench aligns every reprogramming to the cycle just after a pulse. It then times two intervals, the first of which must still show the old modulus. A separate scenario pokes other values partway through a period and restores them before the boundary, and the interval must not change. Doubling is entered and left the same way, so the half-period phase bit is tested across a boundary where its control changes.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  typedef enum logic {
    PS_LO = 1'b0,
    PS_HI = 1'b1
  } ps_mode_e;

  // Limit the sweep length to the supported window.
  function automatic int unsigned clamp_m(input int unsigned m,
                                          input int unsigned lo,
                                          input int unsigned hi);
    if (m < lo) return lo;
    if (m > hi) return hi;
    return m;
  endfunction

  // Full division ratio for one output period.
  function automatic int unsigned fb_modulus(input int unsigned a,
                                             input int unsigned m,
                                             input bit          dbl,
                                             input int unsigned pre_lo);
    int unsigned n;
    n = pre_lo * m + a;
    return dbl ? 2 * n : n;
  endfunction

endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
  import fbdiv_pkg::*;
#(
  parameter int unsigned PRE_LO = 4,
  localparam int unsigned CW    = $clog2(PRE_LO + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  ps_mode_e      mode,
  output logic [CW-1:0] cnt,
  output logic          tc
);

  localparam logic [CW-1:0] LAST_LO = CW'(PRE_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(PRE_LO);

  logic [CW-1:0] last_val;

  always_comb begin
    unique case (mode)
      PS_HI:   last_val = LAST_HI;
      default: last_val = LAST_LO;
    endcase
  end

  assign tc = (cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (tc)         cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow
  import fbdiv_pkg::*;
#(
  parameter int unsigned AW = 2,
  parameter int unsigned MW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [AW-1:0] a_load,
  input  logic [MW-1:0] m_load,
  input  logic          pre_tc,
  output ps_mode_e      mode,
  output logic          sweep_end,
  output logic [AW-1:0] a_left,
  output logic [MW-1:0] m_left
);

  assign mode      = (a_left != '0) ? PS_HI : PS_LO;
  assign sweep_end = pre_tc && (m_left == MW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_left <= '0;
      m_left <= '0;
    end else if (reload) begin
      a_left <= a_load;
      m_left <= m_load;
    end else if (pre_tc) begin
      if (a_left != '0) a_left <= a_left - 1'b1;
      if (m_left != '0) m_left <= m_left - 1'b1;
    end
  end

endmodule

// File: rtl/fbdiv_doubler.sv
module fbdiv_doubler (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sweep_end,
  input  logic dbl,
  output logic half,
  output logic boundary
);

  assign boundary = sweep_end && (!dbl || half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          half <= 1'b0;
    else if (restart)    half <= 1'b0;
    else if (sweep_end)  half <= dbl ? ~half : 1'b0;
  end

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int unsigned PRE_LO = 4,
  parameter int unsigned M_MIN  = 9,
  parameter int unsigned M_MAX  = 98,
  parameter int unsigned AW     = $clog2(PRE_LO),
  parameter int unsigned MW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_in,
  input  logic [MW-1:0] m_in,
  input  logic          dbl_in,
  output logic          pulse_out
);

  localparam int unsigned CW = $clog2(PRE_LO + 1);

  // Named internal events, brought out for the checker.
  logic          primed;
  logic          cfg_take;
  logic          pre_tc;
  logic          sweep_end;
  logic          boundary;
  logic          boundary_g;
  logic          half;
  logic          sel5;
  logic [CW-1:0] presc_cnt;
  ps_mode_e      mode;

  logic [AW-1:0] a_act;
  logic [MW-1:0] m_act;
  logic          dbl_act;
  logic [MW-1:0] m_eff;
  logic [AW-1:0] a_left;
  logic [MW-1:0] m_left;
  logic [AW-1:0] a_next;
  logic [MW-1:0] m_next;
  logic          sw_reload;

  assign m_eff      = MW'(clamp_m(32'(m_in), M_MIN, M_MAX));
  assign boundary_g = primed && boundary;
  assign cfg_take   = !primed || boundary_g;
  assign sw_reload  = cfg_take || sweep_end;
  assign a_next     = cfg_take ? a_in  : a_act;
  assign m_next     = cfg_take ? m_eff : m_act;
  assign sel5       = (mode == PS_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      a_act     <= '0;
      m_act     <= MW'(M_MIN);
      dbl_act   <= 1'b0;
      pulse_out <= 1'b0;
    end else begin
      primed    <= 1'b1;
      pulse_out <= boundary_g;
      if (cfg_take) begin
        a_act   <= a_in;
        m_act   <= m_eff;
        dbl_act <= dbl_in;
      end
    end
  end

  fbdiv_prescaler #(.PRE_LO(PRE_LO)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (!primed),
    .mode    (mode),
    .cnt     (presc_cnt),
    .tc      (pre_tc)
  );

  fbdiv_swallow #(.AW(AW), .MW(MW)) u_swallow (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload    (sw_reload),
    .a_load    (a_next),
    .m_load    (m_next),
    .pre_tc    (pre_tc),
    .mode      (mode),
    .sweep_end (sweep_end),
    .a_left    (a_left),
    .m_left    (m_left)
  );

  fbdiv_doubler u_dbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (!primed),
    .sweep_end (sweep_end),
    .dbl       (dbl_act),
    .half      (half),
    .boundary  (boundary)
  );

endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker
  import fbdiv_pkg::*;
#(
  parameter int unsigned PRE_LO = 4,
  parameter int unsigned AW     = 2,
  parameter int unsigned MW     = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          primed,
  input logic          boundary_g,
  input logic          sweep_end,
  input logic          pre_tc,
  input logic          sel5,
  input logic          pulse_out,
  input logic [AW-1:0] a_act,
  input logic [MW-1:0] m_act,
  input logic          dbl_act,
  input logic [AW-1:0] a_in,
  input logic [MW-1:0] m_in,
  input logic          dbl_in
);

  logic [15:0] per_cnt;
  logic [7:0]  hi_cnt;
  logic [1:0]  sweeps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      hi_cnt  <= '0;
      sweeps  <= '0;
    end else begin
      per_cnt <= (!primed || boundary_g) ? '0 : per_cnt + 1'b1;
      if (!primed || sweep_end)   hi_cnt <= '0;
      else if (pre_tc && sel5)    hi_cnt <= hi_cnt + 1'b1;
      if (!primed || boundary_g)  sweeps <= '0;
      else if (sweep_end)         sweeps <= sweeps + 1'b1;
    end
  end

  // R1: pulse is one clock wide
  a_r1_single_wide: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |=> !pulse_out);

  // R1 / R3: period length matches programmed modulus
  a_r1_period: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_g |-> (32'(per_cnt) + 1 ==
      fb_modulus(32'(a_act), 32'(m_act), dbl_act, PRE_LO)));

  // R2: number of divide-by-5 prescaler cycles equals A
  a_r2_hi_count: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && sweep_end) |->
      (32'(hi_cnt) + (sel5 ? 1 : 0) == 32'(a_act)));

  // R3: doubling yields two sweeps per period
  a_r3_sweeps: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_g |-> (32'(sweeps) + 1 == (dbl_act ? 2 : 1)));

  // R4: active settings change only at a boundary
  a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !boundary_g) |=>
      ($stable(a_act) && $stable(m_act) && $stable(dbl_act)));

  // R4: the boundary samples the inputs
  a_r4_cfg_take: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_g |=> (a_act == $past(a_in) && dbl_act == $past(dbl_in)));

  // R5: active sweep length stays in the clamped window
  a_r5_m_window: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (m_act >= MW'(9) && m_act <= MW'(98)));

  // R6: no pulse before the first sample edge has been consumed
  a_r6_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !pulse_out);

  logic unused_ok;
  assign unused_ok = ^m_in;

endmodule

bind fbdiv_top fbdiv_checker #(.PRE_LO(PRE_LO), .AW(AW), .MW(MW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .primed     (primed),
  .boundary_g (boundary_g),
  .sweep_end  (sweep_end),
  .pre_tc     (pre_tc),
  .sel5       (sel5),
  .pulse_out  (pulse_out),
  .a_act      (a_act),
  .m_act      (m_act),
  .dbl_act    (dbl_act),
  .a_in       (a_in),
  .m_in       (m_in),
  .dbl_in     (dbl_in)
);

// File: tb/sim_fbdiv_top.sv
`timescale 1ns/1ps
module sim_fbdiv_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] a_in = 2'd1;
  logic [6:0] m_in = 7'd9;
  logic       dbl_in = 1'b0;
  logic       pulse_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  fbdiv_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .m_in      (m_in),
    .dbl_in    (dbl_in),
    .pulse_out (pulse_out)
  );

  // Independent restatement of the division ratio.
  function automatic int exp_n(input int a, input int m, input bit d);
    int mm;
    mm = (m < 9) ? 9 : ((m > 98) ? 98 : m);
    return d ? 2 * (mm * 4 + a) : (mm * 4 + a);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count negedges from one sampled pulse to the next; checks width too.
  task automatic measure(input string req, output int n);
    int wide_err;
    n = 0;
    wide_err = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1 && pulse_out) wide_err = 1;
    end while (!pulse_out && n < 2000);
    chk({req, " pulse width"}, wide_err, 0);
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    a_in = 2'd1; m_in = 7'd9; dbl_in = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk("R6 quiet in reset", int'(pulse_out), 0);
    end
    rst_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse_out && n < 2000);
    chk("R6 first pulse latency", n, exp_n(1, 9, 0) + 1);
  endtask

  task automatic t_period(input string req, input int expect_n);
    int n;
    measure(req, n);
    chk(req, n, expect_n);
  endtask

  // Reprogram right after a pulse: one old interval, then the new one.
  task automatic t_switch(input string req, input int a, input int m,
                          input bit d, input int old_n);
    int n;
    a_in = 2'(a); m_in = 7'(m); dbl_in = d;
    measure("R4 old period kept", n);
    chk("R4 old period kept", n, old_n);
    measure(req, n);
    chk(req, n, exp_n(a, m, d));
  endtask

  // Poke other values mid-period and restore before the boundary.
  task automatic t_glitch(input int keep_n);
    int n;
    logic [1:0] sa;
    logic [6:0] sm;
    logic       sd;
    sa = a_in; sm = m_in; sd = dbl_in;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 10) begin a_in = 2'd3; m_in = 7'd50; dbl_in = 1'b1; end
      if (n == 20) begin a_in = sa; m_in = sm; dbl_in = sd; end
    end while (!pulse_out && n < 2000);
    chk("R4 mid-period poke ignored", n, keep_n);
    t_period("R4 following period", keep_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_period("R1 base period 37", 37);
    t_switch("R1 period 392", 0, 98, 1'b0, 37);
    t_switch("R2 A=3 M=20", 3, 20, 1'b0, 392);
    t_switch("R2 A=2 M=20", 2, 20, 1'b0, 83);
    t_switch("R7 A=0 M=10", 0, 10, 1'b0, 82);
    t_switch("R3 doubled 784", 0, 98, 1'b1, 40);
    t_switch("R3 doubled 74", 1, 9, 1'b1, 784);
    t_period("R3 doubled repeat", 74);
    t_switch("R5 low clamp", 0, 3, 1'b0, 74);
    t_switch("R5 high clamp", 2, 127, 1'b0, 36);
    t_switch("R7 A=3 M=9", 3, 9, 1'b0, 394);
    t_glitch(39);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule